// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block holds the control-flow stack of a single warp in a SIMT pipeline and handles branch divergence by dynamic predication. Every stack entry carries the next PC, a reconvergence PC and an active-thread mask. The fetch PC and the lane-enable mask always come from the top entry. When the threads of a warp disagree on a branch, the two sides of the branch run one after the other under complementary masks. The warp merges back to the wider mask as soon as its PC reaches the stored reconvergence point.

The fetch stage presents one of two inputs each cycle. The first is a resolved branch: a per-thread taken mask, the taken target, the fall-through PC and the reconvergence PC, which the branch carries with it. The second is a plain sequential advance to the next PC. On reset the stack holds only a bottom entry. That entry covers all threads, has no reconvergence point and is never popped. Stack depth is a parameter. A branch that would need more entries than remain is dropped, and a sticky overflow flag is raised.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `fetch_pc` equals `RESET_PC`, `lane_mask` is all ones and `overflow` is 0.
- R2: `fetch_pc` and `lane_mask` are the next PC and the mask of the top entry. On the clock edge that samples `adv_valid`, the top entry's next PC becomes `adv_pc`. With no valid input the outputs hold.
- R3: A branch is uniform when (`lane_mask` & `br_taken_mask`) or (`lane_mask` & ~`br_taken_mask`) is zero. A uniform branch pushes nothing. It sets the top next PC to `br_target` if any active lane is taken, and to `br_fallthru` otherwise. Taken bits of inactive lanes have no effect. Bit i of each mask is lane i.
- R4: A divergent branch rewrites the top entry's next PC to `br_reconv`. It then pushes the fall-through path (mask = top mask & ~taken) and, above it, the taken path (mask = top mask & taken). Both pushed entries carry `br_reconv`, so the taken path runs first.
- R5: A path whose start PC equals `br_reconv` is not pushed.
- R6: When a new next PC (from an advance or a uniform branch) equals the top entry's reconvergence PC, the top entry is popped. The outputs then come from the entry below. The bottom entry is never popped.
- R7: When a divergent branch's `br_reconv` equals the reconvergence PC of the current top entry, the pushed paths replace that entry instead of sitting above it. Unwinding then returns directly to the entry below it.
- R8: A divergent branch that would need a slot beyond `DEPTH` entries is ignored as a whole and sets `overflow`, which stays set until reset. A push that exactly fills the stack is not an overflow.
- R9: When `br_valid` and `adv_valid` are both high, the branch is applied and the advance is ignored.
- R10: Divergence nested inside a path pushes further entries, and these unwind in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A resolved branch for the current path |
| br_taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| adv_valid | input | 1 | Sequential advance of the current path |
| adv_pc | input | PC_W | PC the warp fetches next |
| fetch_pc | output | PC_W | Top-of-stack next PC |
| lane_mask | output | LANES | Top-of-stack active mask |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with four lanes, 16-bit PCs and a depth of four. Four lanes are enough to reproduce the if/else sequence 1111, 1110, 0001, 1111 directly. A depth of four lets a two-level nesting reach both cases within a few cycles: a push that exactly fills the stack, and a push one slot past it that must overflow. Lane counts of one and widths near the limit are not exercised.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;
    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_UNIFORM = 2'd1,
        BR_SPLIT   = 2'd2
    } br_kind_e;
endpackage

// File: rtl/rs_path_split.sv
module rs_path_split
    import simt_rs_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input  logic [LANES-1:0] top_mask,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  fall_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    output br_kind_e         kind,
    output logic [PC_W-1:0]  uni_pc,
    output logic [1:0]       n_paths,
    output logic [PC_W-1:0]  p1_pc,
    output logic [LANES-1:0] p1_mask,
    output logic [PC_W-1:0]  p2_pc,
    output logic [LANES-1:0] p2_mask
);
    logic [LANES-1:0] tk_m;
    logic [LANES-1:0] nt_m;
    logic             fall_live;
    logic             tgt_live;

    always_comb begin
        tk_m      = top_mask & taken_mask;
        nt_m      = top_mask & ~taken_mask;
        kind      = ((|tk_m) && (|nt_m)) ? BR_SPLIT : BR_UNIFORM;
        uni_pc    = (|tk_m) ? target_pc : fall_pc;
        fall_live = (fall_pc != reconv_pc);
        tgt_live  = (target_pc != reconv_pc);
        n_paths   = 2'd0;
        p1_pc     = fall_pc;
        p1_mask   = nt_m;
        p2_pc     = target_pc;
        p2_mask   = tk_m;
        if (fall_live && tgt_live) begin
            n_paths = 2'd2;
        end else if (fall_live) begin
            n_paths = 2'd1;
        end else if (tgt_live) begin
            n_paths = 2'd1;
            p1_pc   = target_pc;
            p1_mask = tk_m;
        end
    end
endmodule

// File: rtl/rs_entry_file.sv
module rs_entry_file #(
    parameter int          DEPTH    = 8,
    parameter int          LANES    = 32,
    parameter int          PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int         SP_W     = $clog2(DEPTH),
    localparam int         ENT_W    = 2 * PC_W + LANES + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SP_W-1:0]  rd_idx,
    output logic [ENT_W-1:0] rd_ent,
    input  logic             w0_en,
    input  logic [SP_W-1:0]  w0_idx,
    input  logic [ENT_W-1:0] w0_ent,
    input  logic             w1_en,
    input  logic [SP_W-1:0]  w1_idx,
    input  logic [ENT_W-1:0] w1_ent,
    input  logic             w2_en,
    input  logic [SP_W-1:0]  w2_idx,
    input  logic [ENT_W-1:0] w2_ent
);
    localparam logic [ENT_W-1:0] BOTTOM_ENT = {RESET_PC, {LANES{1'b1}}, {PC_W{1'b0}}, 1'b0};

    logic [ENT_W-1:0] slot_d [DEPTH];
    logic [ENT_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (w0_en && (w0_idx == SP_W'(i))) slot_d[i] = w0_ent;
            if (w1_en && (w1_idx == SP_W'(i))) slot_d[i] = w1_ent;
            if (w2_en && (w2_idx == SP_W'(i))) slot_d[i] = w2_ent;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= (i == 0) ? BOTTOM_ENT : '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign rd_ent = slot_q[rd_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_rs_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter int          LANES    = 32,
    parameter int          DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken_mask,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] lane_mask,
    output logic             overflow
);
    localparam int SP_W  = $clog2(DEPTH);
    localparam int ENT_W = 2 * PC_W + LANES + 1;

    typedef struct packed {
        logic [PC_W-1:0]  nxt;
        logic [LANES-1:0] msk;
        logic [PC_W-1:0]  rpc;
        logic             rok;
    } ent_t;

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            ovf;
    } ctl_t;

    ctl_t st_d, st_q;

    ent_t             top;
    logic [ENT_W-1:0] top_raw;
    logic [PC_W-1:0]  top_rpc;
    logic             top_rok;

    br_kind_e         kind;
    logic [PC_W-1:0]  uni_pc;
    logic [1:0]       n_paths;
    logic [PC_W-1:0]  p1_pc, p2_pc;
    logic [LANES-1:0] p1_mask, p2_mask;

    logic             w0_en, w1_en, w2_en;
    logic [SP_W-1:0]  w1_idx, w2_idx;
    ent_t             w0_ent, w1_ent, w2_ent;

    logic             collapse;
    logic [SP_W-1:0]  base;
    logic [PC_W-1:0]  redir_pc;
    logic             redir;

    rs_entry_file #(
        .DEPTH   (DEPTH),
        .LANES   (LANES),
        .PC_W    (PC_W),
        .RESET_PC(RESET_PC)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(st_q.sp),
        .rd_ent(top_raw),
        .w0_en (w0_en),
        .w0_idx(st_q.sp),
        .w0_ent(w0_ent),
        .w1_en (w1_en),
        .w1_idx(w1_idx),
        .w1_ent(w1_ent),
        .w2_en (w2_en),
        .w2_idx(w2_idx),
        .w2_ent(w2_ent)
    );

    assign top     = ent_t'(top_raw);
    assign top_rpc = top.rpc;
    assign top_rok = top.rok;

    rs_path_split #(
        .LANES(LANES),
        .PC_W (PC_W)
    ) u_split (
        .top_mask  (top.msk),
        .taken_mask(br_taken_mask),
        .target_pc (br_target),
        .fall_pc   (br_fallthru),
        .reconv_pc (br_reconv),
        .kind      (kind),
        .uni_pc    (uni_pc),
        .n_paths   (n_paths),
        .p1_pc     (p1_pc),
        .p1_mask   (p1_mask),
        .p2_pc     (p2_pc),
        .p2_mask   (p2_mask)
    );

    always_comb begin
        st_d     = st_q;
        w0_en    = 1'b0;
        w1_en    = 1'b0;
        w2_en    = 1'b0;
        w0_ent   = top;
        collapse = top.rok && (br_reconv == top.rpc);
        base     = collapse ? (st_q.sp - SP_W'(1)) : st_q.sp;
        w1_idx   = base + SP_W'(1);
        w2_idx   = base + SP_W'(2);
        w1_ent   = '{nxt: p1_pc, msk: p1_mask, rpc: br_reconv, rok: 1'b1};
        w2_ent   = '{nxt: p2_pc, msk: p2_mask, rpc: br_reconv, rok: 1'b1};
        redir    = 1'b0;
        redir_pc = adv_pc;

        if (br_valid) begin
            if (kind == BR_SPLIT) begin
                if ((int'(base) + int'(n_paths)) > (DEPTH - 1)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    if (!collapse) begin
                        w0_en      = 1'b1;
                        w0_ent.nxt = br_reconv;
                    end
                    w1_en   = (n_paths != 2'd0);
                    w2_en   = (n_paths == 2'd2);
                    st_d.sp = base + SP_W'(n_paths);
                end
            end else begin
                redir    = 1'b1;
                redir_pc = uni_pc;
            end
        end else if (adv_valid) begin
            redir = 1'b1;
        end

        if (redir) begin
            if (top.rok && (redir_pc == top.rpc)) begin
                st_d.sp = st_q.sp - SP_W'(1);
            end else begin
                w0_en      = 1'b1;
                w0_ent.nxt = redir_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc  = top.nxt;
    assign lane_mask = top.msk;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int PC_W  = 32,
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic             adv_valid,
    input logic [LANES-1:0] br_taken_mask,
    input logic [PC_W-1:0]  br_target,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [LANES-1:0] lane_mask,
    input logic             overflow,
    input logic [PC_W-1:0]  top_rpc,
    input logic             top_rok
);
    // R8: the overflow flag never clears without reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: the dropped branch leaves the visible path untouched
    a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($stable(fetch_pc) && $stable(lane_mask)));

    // R2: with no valid input the outputs hold
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !adv_valid) |=> ($stable(fetch_pc) && $stable(lane_mask)));

    // R2: some lane is always enabled
    a_r2_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask != '0);

    // R3: all active lanes taken, no pop: jump to target under the same mask
    a_r3_uniform_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && ((br_taken_mask & lane_mask) == lane_mask)
         && !(top_rok && (br_target == top_rpc)))
        |=> ((fetch_pc == $past(br_target)) && (lane_mask == $past(lane_mask))));

    // R6: only the bottom entry lacks a reconvergence point, and it spans all lanes
    a_r6_bottom_full: assert property (@(posedge clk) disable iff (!rst_n)
        !top_rok |-> (lane_mask == '1));
endmodule

bind simt_reconv_stack rs_checker #(
    .PC_W (PC_W),
    .LANES(LANES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .adv_valid    (adv_valid),
    .br_taken_mask(br_taken_mask),
    .br_target    (br_target),
    .fetch_pc     (fetch_pc),
    .lane_mask    (lane_mask),
    .overflow     (overflow),
    .top_rpc      (top_rpc),
    .top_rok      (top_rok)
);

// File: tb/tb_simt_reconv_stack.sv
`timescale 1ns/1ps
module tb_simt_reconv_stack;
    localparam int PC_W  = 16;
    localparam int LANES = 4;
    localparam int DEPTH = 4;
    localparam logic [15:0] RST_PC = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, adv_valid;
    logic [3:0]  br_taken_mask;
    logic [15:0] br_target, br_fallthru, br_reconv, adv_pc;
    logic [15:0] fetch_pc;
    logic [3:0]  lane_mask;
    logic        overflow;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    simt_reconv_stack #(
        .PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH), .RESET_PC(RST_PC)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_taken_mask(br_taken_mask),
        .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .fetch_pc(fetch_pc), .lane_mask(lane_mask), .overflow(overflow)
    );

    // op: 0 idle, 1 advance to c, 2 branch (tk, target a, fall b, reconv c)
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  tk;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic [15:0] epc;
        logic [3:0]  em;
        logic        eo;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0104, 16'h0104, 4'b1111, 1'b0, 4'd2},  // R2
        '{2'd2, 4'b1110, 16'h0200, 16'h0300, 16'h0400, 16'h0200, 4'b1110, 1'b0, 4'd4},  // R4
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0204, 16'h0204, 4'b1110, 1'b0, 4'd2},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0400, 16'h0300, 4'b0001, 1'b0, 4'd6},  // R6
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0304, 16'h0304, 4'b0001, 1'b0, 4'd2},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0400, 16'h0400, 4'b1111, 1'b0, 4'd6},
        '{2'd0, 4'b0000, 16'h0000, 16'h0000, 16'h0000, 16'h0400, 4'b1111, 1'b0, 4'd2},
        '{2'd2, 4'b1111, 16'h0500, 16'h0404, 16'h0600, 16'h0500, 4'b1111, 1'b0, 4'd3},  // R3
        '{2'd2, 4'b0000, 16'h0700, 16'h0504, 16'h0600, 16'h0504, 4'b1111, 1'b0, 4'd3},
        '{2'd2, 4'b0011, 16'h0800, 16'h0900, 16'h0A00, 16'h0800, 4'b0011, 1'b0, 4'd4},
        '{2'd2, 4'b0001, 16'h0810, 16'h0830, 16'h0830, 16'h0810, 4'b0001, 1'b0, 4'd5},  // R5
        '{2'd2, 4'b1100, 16'h0818, 16'h0814, 16'h0830, 16'h0814, 4'b0001, 1'b0, 4'd3},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0830, 16'h0830, 4'b0011, 1'b0, 4'd10}, // R10
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0A00, 16'h0900, 4'b1100, 1'b0, 4'd10},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0A00, 16'h0A00, 4'b1111, 1'b0, 4'd10},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0A00, 16'h0A00, 4'b1111, 1'b0, 4'd6},
        '{2'd2, 4'b0101, 16'h0B00, 16'h0C00, 16'h0D00, 16'h0B00, 4'b0101, 1'b0, 4'd4},
        '{2'd2, 4'b0001, 16'h0B10, 16'h0B20, 16'h0D00, 16'h0B10, 4'b0001, 1'b0, 4'd7},  // R7
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0D00, 16'h0B20, 4'b0100, 1'b0, 4'd7},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0D00, 16'h0C00, 4'b1010, 1'b0, 4'd7},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0D00, 16'h0D00, 4'b1111, 1'b0, 4'd6},
        '{2'd2, 4'b0011, 16'h0E00, 16'h0F00, 16'h1000, 16'h0E00, 4'b0011, 1'b0, 4'd4},
        '{2'd2, 4'b0001, 16'h0E10, 16'h0E20, 16'h0E30, 16'h0E00, 4'b0011, 1'b1, 4'd8},  // R8
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h0E04, 16'h0E04, 4'b0011, 1'b1, 4'd8},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h1000, 16'h0F00, 4'b1100, 1'b1, 4'd8},
        '{2'd1, 4'b0000, 16'h0000, 16'h0000, 16'h1000, 16'h1000, 4'b1111, 1'b1, 4'd8}
    };

    task automatic check(input string req, input logic [15:0] epc,
                         input logic [3:0] em, input logic eo);
        total++;
        if (fetch_pc !== epc || lane_mask !== em || overflow !== eo) begin
            bad++;
            $display("FAIL %s: pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
                     req, fetch_pc, lane_mask, overflow, epc, em, eo);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic apply(input logic bv, input logic av, input logic [3:0] tk,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] apc);
        br_valid      = bv;
        adv_valid     = av;
        br_taken_mask = tk;
        br_target     = a;
        br_fallthru   = b;
        br_reconv     = c;
        adv_pc        = apc;
        @(negedge clk);
        br_valid  = 1'b0;
        adv_valid = 1'b0;
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        br_valid = 1'b0; adv_valid = 1'b0; br_taken_mask = '0;
        br_target = '0; br_fallthru = '0; br_reconv = '0; adv_pc = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", RST_PC, 4'b1111, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", RST_PC, 4'b1111, 1'b0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.op == 2'd2) apply(1'b1, 1'b0, v.tk, v.a, v.b, v.c, 16'h0);
            else if (v.op == 2'd1) apply(1'b0, 1'b1, 4'b0, 16'h0, 16'h0, 16'h0, v.c);
            else apply(1'b0, 1'b0, 4'b0, 16'h0, 16'h0, 16'h0, 16'h0);
            check($sformatf("R%0d vector %0d", v.rq, i), v.epc, v.em, v.eo);
        end

        // R1: reset mid-run clears overflow and the stack
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", RST_PC, 4'b1111, 1'b0);

        // R4 then R8: filling the last slot exactly is not an overflow (R5 drops the fall path)
        apply(1'b1, 1'b0, 4'b0011, 16'h0E00, 16'h0F00, 16'h1000, 16'h0);
        check("R4 split before fill", 16'h0E00, 4'b0011, 1'b0);
        apply(1'b1, 1'b0, 4'b0001, 16'h0E10, 16'h0E30, 16'h0E30, 16'h0);
        check("R8 exact fill", 16'h0E10, 4'b0001, 1'b0);

        // R9: branch wins over a simultaneous advance that would have popped
        apply(1'b1, 1'b1, 4'b0001, 16'h0E14, 16'h0E18, 16'h0E30, 16'h0E30);
        check("R9 branch priority", 16'h0E14, 4'b0001, 1'b0);

        // R6: a uniform branch landing on the reconvergence point pops
        apply(1'b1, 1'b0, 4'b1111, 16'h0E30, 16'h0E18, 16'h0F30, 16'h0);
        check("R6 uniform pop", 16'h0E30, 4'b0011, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule